// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

A memory-mapped general-purpose I/O port of 32 pins. A word-wide register bus (address, write strobe, write data, registered read data) controls an output latch and a direction latch whose contents drive the pads directly. Both latches can be loaded whole or updated through write-one set and clear aliases, so software can change a few pins without a read-modify-write sequence.

Every pin can also raise an interrupt. Pad inputs are first resynchronized by two flops. A per-pin selector chooses edge or level sensing, the polarity, and a both-edges option. Events are latched into a pending register that software clears by writing ones. Pending bits are masked by a per-pin enable, which also has set and clear aliases. The result is merged into a single registered interrupt line for the port.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, every register is zero, and pad_out, pad_oe, irq and bus_rdata are all zero.
- R2: Offset 0x00 loads the output latch whole. A write to 0x40 sets each output bit written as one, and a write to 0x44 clears each such bit. Bits written as zero keep their value. pad_out always equals the output latch.
- R3: Offset 0x08 loads the direction latch whole. 0x48 sets selected bits (pin becomes an output, bit 1), and 0x4C clears them (pin becomes an input, bit 0). pad_oe always equals the direction latch.
- R4: Reading 0x04 returns pad_in after a two-flop synchronizer, so a pad change is visible two clock edges later. Writes to 0x04 change nothing.
- R5: bus_rdata is registered: it shows the register selected by bus_addr one clock after the address is presented. The set and clear aliases read back their underlying latch, and any offset not in the map reads as zero.
- R6: When a pin's bit at 0x2C is 0, the pin is edge-sensitive. Its bit at 0x18 selects rising (0) or falling (1), and a 1 in its bit at 0x1C selects both edges, regardless of 0x18.
- R7: When a pin's bit at 0x2C is 1, the pin is level-sensitive. Its bit at 0x18 selects high (0) or low (1). The pending bit is set again on every cycle the active level is present, so clearing it while the level persists has no lasting effect.
- R8: Offset 0x20 reads all pending bits. Writing a one clears that pending bit, and a zero leaves it alone. An event in the same cycle as the clear keeps the bit set.
- R9: A write to 0x30 sets the written interrupt-enable bits, and a write to 0x34 clears them. Reading either offset returns the enable bits.
- R10: irq is high one cycle after any pending bit is also enabled. Pending bits still latch while their enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined port interrupt |

## Verification
The checker watches every cycle for the effect of the set and clear aliases on the output, direction and enable latches, and for write-one clearing of pending bits that have no new event. It also checks that the interrupt line follows the masked pending bits by exactly one cycle and that input reads return the synchronized pads. Only the bench's scenarios can show that each trigger mode catches its own stimulus and ignores the opposite one, and that a level source re-arms its bit after a clear. They also cover an edge that coincides with a clear winning over it, and latching while an enable is off.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [7:0] OFF_OUT     = 8'h00;
  localparam logic [7:0] OFF_IN      = 8'h04;
  localparam logic [7:0] OFF_DIR     = 8'h08;
  localparam logic [7:0] OFF_POL     = 8'h18;
  localparam logic [7:0] OFF_BOTH    = 8'h1C;
  localparam logic [7:0] OFF_PEND    = 8'h20;
  localparam logic [7:0] OFF_LVL     = 8'h2C;
  localparam logic [7:0] OFF_EN_SET  = 8'h30;
  localparam logic [7:0] OFF_EN_CLR  = 8'h34;
  localparam logic [7:0] OFF_OUT_SET = 8'h40;
  localparam logic [7:0] OFF_OUT_CLR = 8'h44;
  localparam logic [7:0] OFF_DIR_SET = 8'h48;
  localparam logic [7:0] OFF_DIR_CLR = 8'h4C;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] now_v,
  output logic [W-1:0] last_v
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      now_v  <= '0;
      last_v <= '0;
    end else begin
      meta_q <= raw;
      now_v  <= meta_q;
      last_v <= now_v;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] now_v,
  input  logic [W-1:0] last_v,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] neg_sel,
  input  logic [W-1:0] both_sel,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = now_v[i] & ~last_v[i];
      fall     = ~now_v[i] & last_v[i];
      lvl_hit  = now_v[i] ^ neg_sel[i];
      if (both_sel[i])     edge_hit = rise | fall;
      else if (neg_sel[i]) edge_hit = fall;
      else                 edge_hit = rise;
      hit[i]   = lvl_sel[i] ? lvl_hit : edge_hit;
    end
  end
endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | hit;
      irq  <= |(pend & en);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] out_q, dir_q, en_q, lvl_q, pol_q, both_q;
  logic [NPINS-1:0] sync_v, prev_v, ev, pend_q, pend_clr;
  logic [NPINS-1:0] rd_mux;

  assign wd = bus_wdata[NPINS-1:0];

  function automatic logic wr_at(input logic [7:0] off);
    return bus_we && (bus_addr == AW'(off));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      if (wr_at(OFF_OUT))          out_q <= wd;
      else if (wr_at(OFF_OUT_SET)) out_q <= out_q | wd;
      else if (wr_at(OFF_OUT_CLR)) out_q <= out_q & ~wd;

      if (wr_at(OFF_DIR))          dir_q <= wd;
      else if (wr_at(OFF_DIR_SET)) dir_q <= dir_q | wd;
      else if (wr_at(OFF_DIR_CLR)) dir_q <= dir_q & ~wd;

      if (wr_at(OFF_EN_SET))       en_q <= en_q | wd;
      else if (wr_at(OFF_EN_CLR))  en_q <= en_q & ~wd;

      if (wr_at(OFF_LVL))  lvl_q  <= wd;
      if (wr_at(OFF_POL))  pol_q  <= wd;
      if (wr_at(OFF_BOTH)) both_q <= wd;
    end
  end

  assign pend_clr = wr_at(OFF_PEND) ? wd : '0;

  gpio_pin_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .raw(pad_in), .now_v(sync_v), .last_v(prev_v)
  );

  gpio_trig_detect #(.W(NPINS)) u_trig (
    .now_v(sync_v), .last_v(prev_v), .lvl_sel(lvl_q), .neg_sel(pol_q),
    .both_sel(both_q), .hit(ev)
  );

  gpio_irq_capture #(.W(NPINS)) u_cap (
    .clk(clk), .rst(rst), .hit(ev), .clr(pend_clr), .en(en_q),
    .pend(pend_q), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      AW'(OFF_OUT), AW'(OFF_OUT_SET), AW'(OFF_OUT_CLR): rd_mux = out_q;
      AW'(OFF_DIR), AW'(OFF_DIR_SET), AW'(OFF_DIR_CLR): rd_mux = dir_q;
      AW'(OFF_EN_SET), AW'(OFF_EN_CLR):                 rd_mux = en_q;
      AW'(OFF_IN):   rd_mux = sync_v;
      AW'(OFF_POL):  rd_mux = pol_q;
      AW'(OFF_BOTH): rd_mux = both_q;
      AW'(OFF_LVL):  rd_mux = lvl_q;
      AW'(OFF_PEND): rd_mux = pend_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= DW'(rd_mux);
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] ev,
  input logic [NPINS-1:0] sync_v
);
  logic [NPINS-1:0] wd;
  assign wd = bus_wdata[NPINS-1:0];

  p_out_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_OUT_SET)) |=> ((pad_out & $past(wd)) == $past(wd)));
  p_out_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_OUT_CLR)) |=> ((pad_out & $past(wd)) == '0));
  p_dir_set_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_DIR_SET)) |=> ((pad_oe & $past(wd)) == $past(wd)));
  p_dir_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_DIR_CLR)) |=> ((pad_oe & $past(wd)) == '0));
  p_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(OFF_IN)) |=> (bus_rdata == DW'($past(sync_v))));
  p_pend_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_PEND)) |=> ((pend & $past(wd & ~ev)) == '0));
  p_event_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));
  p_en_set_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_EN_SET)) |=> ((en & $past(wd)) == $past(wd)));
  p_en_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_EN_CLR)) |=> ((en & $past(wd)) == '0));
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
    ((pend & en) != '0) |=> irq);
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
    ((pend & en) == '0) |=> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .pend(pend_q), .en(en_q), .ev(ev),
  .sync_v(sync_v)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {level, negative, both, pad before, pad after, expected pending}
  localparam logic [5:0] VEC [10] = '{
    6'b000_01_1, 6'b000_10_0, 6'b010_10_1, 6'b010_01_0, 6'b001_01_1,
    6'b001_10_1, 6'b100_11_1, 6'b100_00_0, 6'b110_00_1, 6'b110_11_0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); rv = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(8'h00); check("R1 out reg", rv, 32'h0);
    rd(8'h20); check("R1 pending", rv, 32'h0);

    // trigger mode table on pin 0 (R6, R7)
    for (int i = 0; i < 10; i++) begin
      wr(8'h2C, {31'b0, VEC[i][5]});
      wr(8'h18, {31'b0, VEC[i][4]});
      wr(8'h1C, {31'b0, VEC[i][3]});
      pad_in[0] = VEC[i][2];
      idle(4);
      wr(8'h20, 32'hFFFF_FFFF);
      pad_in[0] = VEC[i][1];
      idle(4);
      rd(8'h20);
      check(VEC[i][5] ? "R7 level mode" : "R6 edge mode", {31'b0, rv[0]}, {31'b0, VEC[i][0]});
    end
    wr(8'h2C, 32'h0); wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
    pad_in[0] = 1'b0; idle(4); wr(8'h20, 32'hFFFF_FFFF);

    // R2 output latch
    wr(8'h00, 32'hA5A5_0000);
    wr(8'h40, 32'h0000_00F1);
    wr(8'h44, 32'h8000_0001);
    check("R2 pad_out", pad_out, 32'h25A5_00F0);
    rd(8'h44); check("R2 alias readback", rv, 32'h25A5_00F0);

    // R3 direction latch
    wr(8'h08, 32'h0000_FF00);
    wr(8'h48, 32'h0001_0000);
    wr(8'h4C, 32'h0000_0F00);
    check("R3 pad_oe", pad_oe, 32'h0001_F000);
    rd(8'h08); check("R3 dir readback", rv, 32'h0001_F000);

    // R4 input synchronizer and ignored write
    pad_in[31:24] = 8'h5A;
    @(negedge clk); bus_addr = 8'h04;
    @(negedge clk); check("R4 sync one edge", bus_rdata & 32'hFF00_0000, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R4 sync value", bus_rdata & 32'hFF00_0000, 32'h5A00_0000);
    wr(8'h04, 32'h00FF_FFFF);
    rd(8'h04); check("R4 write ignored", rv & 32'h00FF_FFFF, 32'h0);

    // R5 unmapped offset
    rd(8'h10); check("R5 unmapped", rv, 32'h0);

    // R10 latch while disabled, then enable
    wr(8'h20, 32'hFFFF_FFFF);
    pad_in[2] = 1'b1; idle(5);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h20); check("R10 latched while disabled", rv & 32'h0000_FFFF, 32'h0000_0004);
    wr(8'h30, 32'h0000_0004);
    idle(1);
    check("R10 irq asserted", {31'b0, irq}, 32'h1);
    rd(8'h34); check("R9 enable readback", rv, 32'h0000_0004);
    wr(8'h34, 32'h0000_0004);
    idle(1);
    check("R9 irq after disable", {31'b0, irq}, 32'h0);

    // R8 partial clear and edge winning over clear
    pad_in[4] = 1'b1; idle(5);
    @(negedge clk); pad_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = 8'h20; bus_we = 1'b1; bus_wdata = 32'h0000_0018;
    @(negedge clk); bus_we = 1'b0;
    rd(8'h20); check("R8 edge beats clear", rv & 32'h0000_001C, 32'h0000_000C);

    // R7 level re-arms after clear, then clears once level goes away
    wr(8'h2C, 32'h0000_0002);
    pad_in[1] = 1'b1; idle(4);
    wr(8'h20, 32'h0000_0002); idle(2);
    rd(8'h20); check("R7 level re-arm", rv & 32'h2, 32'h2);
    pad_in[1] = 1'b0; idle(4);
    wr(8'h20, 32'h0000_0002); idle(2);
    rd(8'h20); check("R7 level gone", rv & 32'h2, 32'h0);

    finish_up();
  end
endmodule